// File: doc/BRIEF.md
# Synchronous 32-Word Data Memory with Write Priority

This block is a small clocked scratch memory of 32 words, 16 bits each. A client presents a 16-bit address, write data and two enables. On a rising clock edge with the write enable high, the write data is stored in the addressed word. On a rising edge with only the read enable high, the addressed word is loaded into an output register. The new value appears on the read-data port just after that edge.

When both enables are high on the same edge, the write wins. The word is stored and no read takes place, so the output register keeps its old value. Only the five low address bits choose a word. Addresses that differ only in the upper eleven bits reach the same word.

Word contents are not cleared by reset. A synchronous active-low reset clears only the output register.

Top module: `dmem_sync32`

## Requirements
- R1: After a rising edge with `rst_n` low, `rd_data` reads 0.
- R2: A rising edge with `wr_en` high stores `wr_data` into the word chosen by `addr[4:0]`.
- R3: A rising edge with `rd_en` high and `wr_en` low loads the word chosen by `addr[4:0]` into `rd_data`, visible after that edge.
- R4: On a rising edge with both `wr_en` and `rd_en` high, the write of R2 is performed and `rd_data` keeps its previous value.
- R5: On a rising edge with `rd_en` low, `rd_data` keeps its previous value whatever `addr` and `wr_data` carry.
- R6: `addr[15:5]` has no effect: two addresses with equal `addr[4:0]` select the same word.
- R7: A read returns the data of the most recent write to that word on an earlier edge, including when the word was overwritten.
- R8: The 32 words are independent: a write to one word leaves the other 31 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| addr | input | 16 | Word address; only bits [4:0] are decoded |
| wr_data | input | 16 | Data to store |
| wr_en | input | 1 | Write request; has priority over a read |
| rd_en | input | 1 | Read request |
| rd_data | output | 16 | Registered read result |

## Verification
Every word is first filled with a value derived arithmetically from its index. The whole array is then read back in a full sweep, using addresses whose upper bits carry changing junk. A wrong word decode or a dependence on the upper bits shows up as a mismatch.

A second pass overwrites every word through one alias address and reads it back through another. This separates "latest write" from "first write" and confirms that no neighbour changed.

Cycles with both enables high are placed right after reads whose results are known. This tells a read that was suppressed apart from one that still happened. Idle cycles with moving address and data confirm that the output register holds.

// File: rtl/dmem_pkg.sv
// Package: shared sizing and the request decode type for the data memory.
// Assumes DEPTH is a power of two so the index is a plain bit slice.
package dmem_pkg;
    localparam int unsigned DMEM_ADDR_W = 16;
    localparam int unsigned DMEM_DATA_W = 16;
    localparam int unsigned DMEM_DEPTH  = 32;

    // Which action one clock edge performs.
    typedef enum logic [1:0] {
        DMEM_OP_IDLE  = 2'd0,
        DMEM_OP_READ  = 2'd1,
        DMEM_OP_WRITE = 2'd2
    } dmem_op_e;
endpackage

// File: rtl/dmem_ctrl.sv
// Module: dmem_ctrl
// Turns the two request enables into one action per edge.
// A write always beats a read.
// Assumes the enables are stable around the rising edge.
module dmem_ctrl
    import dmem_pkg::*;
(
    input  logic wr_en,
    input  logic rd_en,
    output logic wr_fire,
    output logic rd_fire
);
    dmem_op_e op;

    // Priority decode: write first, then read, else idle.
    always_comb begin
        if (wr_en)      op = DMEM_OP_WRITE;
        else if (rd_en) op = DMEM_OP_READ;
        else            op = DMEM_OP_IDLE;
    end

    // Expand the chosen action into strobes.
    always_comb begin
        wr_fire = (op == DMEM_OP_WRITE);
        rd_fire = (op == DMEM_OP_READ);
    end
endmodule

// File: rtl/dmem_array.sv
// Module: dmem_array
// Register-based word storage with one write port and one combinational read tap.
// Contents are never reset.
// Assumes idx is already reduced to the index width.
module dmem_array #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_fire,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rword
);
    logic [DATA_W-1:0] words [DEPTH];
    logic [DEPTH-1:0]  row_sel;

    // One-hot row select, one comparator per word.
    for (genvar g = 0; g < DEPTH; g++) begin : g_row_sel
        assign row_sel[g] = (idx == IDX_W'(g));
    end

    // Store the write data into the selected word on the edge.
    always_ff @(posedge clk) begin
        for (int r = 0; r < DEPTH; r++) begin
            if (wr_fire && row_sel[r]) words[r] <= wdata;
        end
    end

    // Read tap that feeds the output register.
    always_comb rword = words[idx];
endmodule

// File: rtl/dmem_rdreg.sv
// Module: dmem_rdreg
// Output register of the read path.
// Loads only on a granted read and holds otherwise.
// Assumes a synchronous active-low reset.
module dmem_rdreg #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] q
);
    // Capture the tapped word on a granted read; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (rd_fire) q <= rword;
    end
endmodule

// File: rtl/dmem_sync32.sv
// Module: dmem_sync32 (top)
// Clocked 32x16 data memory with a registered, enable-gated read and write priority.
// Decodes only the low index bits of the address.
module dmem_sync32
    import dmem_pkg::*;
#(
    parameter int unsigned ADDR_W = DMEM_ADDR_W,
    parameter int unsigned DATA_W = DMEM_DATA_W,
    parameter int unsigned DEPTH  = DMEM_DEPTH,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    logic              wr_fire;
    logic              rd_fire;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rword;

    // Word index: the low address bits only.
    always_comb idx = addr[IDX_W-1:0];

    dmem_ctrl u_ctrl (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_fire (wr_fire),
        .rd_fire (rd_fire)
    );

    dmem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .wr_fire (wr_fire),
        .idx     (idx),
        .wdata   (wr_data),
        .rword   (rword)
    );

    dmem_rdreg #(.DATA_W(DATA_W)) u_rdreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_fire (rd_fire),
        .rword   (rword),
        .q       (rd_data)
    );
endmodule

// File: rtl/dmem_sync32_sva.sv
// Module: dmem_sync32_sva
// Port-level checker for dmem_sync32, attached through bind.
// Keeps a shadow copy of the words written so far.
module dmem_sync32_sva #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sh [DEPTH];
    logic [DEPTH-1:0]  sh_ok;
    logic [IDX_W-1:0]  cur_idx;
    logic [DATA_W-1:0] sh_word;

    always_comb cur_idx = addr[IDX_W-1:0];
    always_comb sh_word = sh[cur_idx];

    // Shadow contents follow every write.
    always_ff @(posedge clk) begin
        if (wr_en) sh[cur_idx] <= wr_data;
    end

    // Track which shadow words hold a known value.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh_ok <= '0;
        else if (wr_en) sh_ok[cur_idx] <= 1'b1;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0);

    a_r3_read_returns_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && sh_ok[cur_idx]) |=> rd_data == $past(sh_word));

    a_r4_write_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(rd_data));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    a_r6_alias_same_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && $past(wr_en) && $past(rst_n)
         && ($past(addr[IDX_W-1:0]) == addr[IDX_W-1:0]) && ($past(addr) != addr))
        |=> rd_data == $past(wr_data, 2));
endmodule

bind dmem_sync32 dmem_sync32_sva #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_data (wr_data),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data)
);

// File: tb/dmem_sync32_bench.sv
module dmem_sync32_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [32];
    logic [15:0] exp_out = '0;

    always #10 clk = ~clk;   // 50 MHz

    dmem_sync32 u_dmem_sync32 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data)
    );

    function automatic logic [15:0] pat(input int i, input int pass);
        return 16'((i * 16'h0841) ^ (pass * 16'h5A5A) ^ 16'h1234);
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one edge worth of inputs at negedge, then sample after the rising edge.
    task automatic step(input logic we, input logic re, input logic [15:0] a,
                        input logic [15:0] d, input string req);
        @(negedge clk);
        wr_en = we; rd_en = re; addr = a; wr_data = d;
        if (we)      model[a[4:0]] = d;          // write wins; output unchanged
        else if (re) exp_out = model[a[4:0]];
        @(posedge clk); #1;
        check(rd_data, exp_out, req);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset clears the output register
        repeat (3) @(posedge clk);
        #1; check(rd_data, 16'h0000, "R1");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1; check(rd_data, 16'h0000, "R1");

        // R2/R5: fill every word, with no read enable the output holds
        for (int i = 0; i < 32; i++)
            step(1'b1, 1'b0, 16'(i), pat(i, 0), "R2_R5");

        // R3/R6/R8: read every word through addresses with junk upper bits
        for (int i = 0; i < 32; i++)
            step(1'b0, 1'b1, 16'(i) | 16'((i * 11 + 7) << 5), pat(i, 0), "R3_R6_R8");

        // R4: both enables after a known read; output must not change
        step(1'b0, 1'b1, 16'd9, 16'h0, "R3");
        step(1'b1, 1'b1, 16'd9, 16'hBEEF, "R4");
        step(1'b1, 1'b1, 16'd20, 16'hCAFE, "R4");
        step(1'b0, 1'b1, 16'd9, 16'h0, "R2_R4");
        step(1'b0, 1'b1, 16'd20, 16'h0, "R2_R4");

        // R5: idle cycles with moving address and data
        for (int i = 0; i < 8; i++)
            step(1'b0, 1'b0, 16'(i * 4099), 16'(i * 777), "R5");

        // R6/R7/R8: overwrite through one alias, read back through another
        for (int i = 0; i < 32; i++) begin
            step(1'b1, 1'b0, 16'hFFE0 | 16'(i), pat(i, 1), "R6_R7");
            step(1'b0, 1'b1, 16'h0420 | 16'(i), pat(i, 1), "R6_R7");
        end
        for (int i = 0; i < 32; i++)
            step(1'b0, 1'b1, 16'(i), pat(i, 1), "R7_R8");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule